// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache that sits between a processor and main memory. It uses byte addresses. Each cache line has a valid flag, a stored tag and a block of data words. The lookup location is fixed by the address bits, so each memory line can live in exactly one slot. Two memory lines that share an index push each other out.

Reads that hit return the selected word in the same cycle. A read miss holds the processor on `cpu_stall`. While stalled, the cache first lets every posted write reach memory. It then requests the whole line from memory, takes the words in ascending order and installs them. The stall then drops and the requested word is delivered.

Every accepted write goes into a small FIFO, and the FIFO drains to memory through a valid/ready handshake. A write that hits also updates the cached word. A write that misses leaves the cache untouched. After reset the valid flags are cleared, one line per cycle by default or all at once as an option. Requests are held off until this clearing is finished.

Top module: `dcache_wt`

## Requirements
- R1: With the default widths, the address splits from bit 31 down into tag [31:16], line index [15:5], word select [4:2] and byte select [1:0]. The byte select does not change which word a read returns.
- R2: After reset, every request stalls until all valid flags are cleared. With sweep clearing this takes one cycle per line, so the first read miss ends 2^IDX_W + 9 cycles after the request is first driven. No stale line ever hits.
- R3: A read whose indexed line is valid with an equal tag sees `cpu_stall` low in the same cycle, with the addressed word on `cpu_rdata`, and issues no memory read.
- R4: A read miss stalls. It raises `mem_rd_req` for exactly one cycle with the line-aligned address (low 5 bits zero). It stores the 8 returned beats as words 0 to 7. It drops `cpu_stall` in the cycle after the last beat, and with an empty write buffer this is 10 cycles after the request first appears.
- R5: Each accepted write appears on the memory write port once, in acceptance order, with its byte-select bits cleared. The head entry holds still while `mem_wr_ready` is low.
- R6: A write that hits replaces only the addressed word in the cache, and a later read hit returns the new value.
- R7: A write that misses does not allocate and does not disturb the line held at that index.
- R8: The write buffer holds 4 entries. A write arriving when it is full stalls until one entry has drained to memory.
- R9: A read miss does not raise `mem_rd_req` while any posted write is still pending, so a refill always returns the latest written data.
- R10: Two addresses that differ only in tag bits (byte 0 and byte 65536 by default) share one line, and each evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request, held with address and data until `cpu_stall` is low at a clock edge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_stall | output | 1 | Request not taken this cycle |
| cpu_rdata | output | DATA_W | Read word, valid when a read is not stalled |
| mem_rd_req | output | 1 | One-cycle line refill request |
| mem_rd_addr | output | ADDR_W | Line-aligned refill address |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | DATA_W | Refill word, ascending word order |
| mem_wr_valid | output | 1 | Posted write available |
| mem_wr_ready | input | 1 | Memory takes the posted write |
| mem_wr_addr | output | ADDR_W | Word-aligned write address |
| mem_wr_data | output | DATA_W | Write word |

## Verification
Read hits and write acceptances are combinational results of the cycle in which the request is driven. The bench samples `cpu_stall` and `cpu_rdata` a quarter period after the falling edge on which it drove the request. A refill takes one cycle to leave the lookup state, one cycle to issue the request and eight beat cycles. The bench therefore counts falling edges from the request to the first low `cpu_stall` and compares against 10 (or 2^IDX_W + 9 straight after reset). Posted writes are compared against the bench's own queue on the clock edge of each handshake. Stalls caused by a full buffer are probed at fixed edges before and after the bench raises `mem_wr_ready`.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
   typedef enum logic [1:0] {
      CS_LOOKUP = 2'd0,
      CS_DRAIN  = 2'd1,
      CS_FILL   = 2'd2
   } ctl_state_e;
endpackage

// File: rtl/dcache_wbuf.sv
module dcache_wbuf #(
   parameter int W     = 64,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   output logic         full,
   output logic         empty,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("dcache_wbuf: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] fill_q;
   logic             pop;

   assign empty     = (fill_q == '0);
   assign full      = (fill_q == CNT_W'(DEPTH));
   assign out_valid = !empty;
   assign out_data  = slot_q[head_q];
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (push) slot_q[tail_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         fill_q <= '0;
      end else begin
         if (push) tail_q <= tail_q + 1'b1;
         if (pop)  head_q <= head_q + 1'b1;
         case ({push, pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_head_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dcache_lines.sv
module dcache_lines #(
   parameter int IDX_W     = 11,
   parameter int TAG_W     = 16,
   parameter int WSEL_W    = 3,
   parameter int DATA_W    = 32,
   parameter bit FLASH_CLR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [WSEL_W-1:0] lk_wsel,
   output logic              hit,
   output logic [DATA_W-1:0] rd_word,
   output logic              init_done,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fill_en,
   input  logic [WSEL_W-1:0] fill_wsel,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              fill_commit
);
   localparam int NLINES = 1 << IDX_W;
   localparam int WORDS  = 1 << WSEL_W;
   localparam int LINE_W = WORDS * DATA_W;

   logic [LINE_W-1:0] line_q [NLINES];
   logic [TAG_W-1:0]  tag_q  [NLINES];
   logic [NLINES-1:0] valid_q;
   logic              done_q;

   assign init_done = done_q;
   assign hit       = done_q && valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign rd_word   = line_q[lk_idx][int'(lk_wsel)*DATA_W +: DATA_W];

   always_ff @(posedge clk) begin
      if (wr_en)       line_q[lk_idx][int'(lk_wsel)*DATA_W +: DATA_W]   <= wr_data;
      if (fill_en)     line_q[lk_idx][int'(fill_wsel)*DATA_W +: DATA_W] <= fill_data;
      if (fill_commit) tag_q[lk_idx] <= lk_tag;
   end

   if (FLASH_CLR) begin : g_flash
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= '0;
            done_q  <= 1'b0;
         end else begin
            done_q <= 1'b1;
            if (fill_commit) valid_q[lk_idx] <= 1'b1;
         end
      end
   end else begin : g_sweep
      logic [IDX_W-1:0] clr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            clr_q  <= '0;
            done_q <= 1'b0;
         end else if (!done_q) begin
            clr_q <= clr_q + 1'b1;
            if (&clr_q) done_q <= 1'b1;
         end
      end
      always_ff @(posedge clk) begin
         if (!done_q)          valid_q[clr_q]  <= 1'b0;
         else if (fill_commit) valid_q[lk_idx] <= 1'b1;
      end
   end

   assert_init_stays_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);
   assert_no_fill_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en || wr_en) |-> done_q);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
   import dcache_pkg::*;
#(
   parameter int WSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              init_done,
   input  logic              hit,
   input  logic              wb_full,
   input  logic              wb_empty,
   input  logic              mem_rd_valid,
   output logic              cpu_stall,
   output logic              wb_push,
   output logic              wr_en,
   output logic              mem_rd_req,
   output logic              fill_en,
   output logic [WSEL_W-1:0] fill_wsel,
   output logic              fill_commit
);
   ctl_state_e        state_q;
   logic [WSEL_W-1:0] beat_q;
   logic              ready_lk, take_rd, take_wr, rd_miss;

   assign ready_lk    = (state_q == CS_LOOKUP) && init_done && cpu_req;
   assign take_rd     = ready_lk && !cpu_we && hit;
   assign take_wr     = ready_lk && cpu_we && !wb_full;
   assign rd_miss     = ready_lk && !cpu_we && !hit;
   assign cpu_stall   = cpu_req && !(take_rd || take_wr);
   assign wb_push     = take_wr;
   assign wr_en       = take_wr && hit;
   assign mem_rd_req  = (state_q == CS_DRAIN) && wb_empty;
   assign fill_en     = (state_q == CS_FILL) && mem_rd_valid;
   assign fill_wsel   = beat_q;
   assign fill_commit = fill_en && (&beat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CS_LOOKUP;
         beat_q  <= '0;
      end else begin
         case (state_q)
            CS_LOOKUP: if (rd_miss) state_q <= CS_DRAIN;
            CS_DRAIN: if (wb_empty) begin
               state_q <= CS_FILL;
               beat_q  <= '0;
            end
            CS_FILL: if (fill_en) begin
               beat_q <= beat_q + 1'b1;
               if (fill_commit) state_q <= CS_LOOKUP;
            end
            default: state_q <= CS_LOOKUP;
         endcase
      end
   end

   assert_single_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);
   assert_read_only_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && !cpu_stall) |-> hit);
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 11,
   parameter int WSEL_W    = 3,
   parameter int DATA_W    = 32,
   parameter int WB_DEPTH  = 4,
   parameter bit FLASH_CLR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_stall,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);
   localparam int BSEL_W = $clog2(DATA_W / 8);
   localparam int LOW_W  = WSEL_W + BSEL_W;
   localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;
   localparam int ENT_W  = ADDR_W + DATA_W;

   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_data
      $error("dcache_wt: DATA_W must be a multiple of 8, at least 16");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dcache_wt: address too narrow for index and offset");
   end

   logic [TAG_W-1:0]  a_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [WSEL_W-1:0] a_wsel;
   logic [BSEL_W-1:0] byte_sel_unused;
   logic              hit, init_done, wb_full, wb_empty, wb_push, wr_en;
   logic              fill_en, fill_commit;
   logic [WSEL_W-1:0] fill_wsel;
   logic [ENT_W-1:0]  wb_in, wb_out;

   assign a_tag           = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx           = cpu_addr[LOW_W +: IDX_W];
   assign a_wsel          = cpu_addr[BSEL_W +: WSEL_W];
   assign byte_sel_unused = cpu_addr[BSEL_W-1:0];
   assign mem_rd_addr     = {a_tag, a_idx, {LOW_W{1'b0}}};
   assign wb_in           = {cpu_addr[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}, cpu_wdata};
   assign mem_wr_addr     = wb_out[ENT_W-1 -: ADDR_W];
   assign mem_wr_data     = wb_out[DATA_W-1:0];

   dcache_lines #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W),
      .DATA_W(DATA_W), .FLASH_CLR(FLASH_CLR)
   ) lines_i (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(a_idx), .lk_tag(a_tag), .lk_wsel(a_wsel),
      .hit(hit), .rd_word(cpu_rdata), .init_done(init_done),
      .wr_en(wr_en), .wr_data(cpu_wdata),
      .fill_en(fill_en), .fill_wsel(fill_wsel), .fill_data(mem_rd_data),
      .fill_commit(fill_commit)
   );

   dcache_wbuf #(.W(ENT_W), .DEPTH(WB_DEPTH)) wbuf_i (
      .clk(clk), .rst_n(rst_n),
      .push(wb_push), .push_data(wb_in),
      .full(wb_full), .empty(wb_empty),
      .out_valid(mem_wr_valid), .out_data(wb_out), .out_ready(mem_wr_ready)
   );

   dcache_ctrl #(.WSEL_W(WSEL_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we),
      .init_done(init_done), .hit(hit),
      .wb_full(wb_full), .wb_empty(wb_empty),
      .mem_rd_valid(mem_rd_valid),
      .cpu_stall(cpu_stall), .wb_push(wb_push), .wr_en(wr_en),
      .mem_rd_req(mem_rd_req),
      .fill_en(fill_en), .fill_wsel(fill_wsel), .fill_commit(fill_commit)
   );

   assert_rd_waits_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !mem_wr_valid);
   assert_no_accept_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_stall) |-> init_done);
   assert_wr_addr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_addr[BSEL_W-1:0] == '0));
endmodule

// File: tb/dcache_wt_tb.sv
module dcache_wt_tb_top;
   localparam int CLK_P  = 10;
   localparam int AW     = 16;
   localparam int IW     = 3;
   localparam int NLINES = 1 << IW;
   localparam int MWORDS = 1 << (AW - 2);

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_stall;
   logic [31:0] cpu_rdata;
   logic        mem_rd_req;
   logic [AW-1:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        mem_wr_valid;
   logic        mem_wr_ready = 1'b1;
   logic [AW-1:0] mem_wr_addr;
   logic [31:0] mem_wr_data;

   int n_chk = 0, n_fail = 0, rd_cnt = 0;
   logic [31:0] mem [MWORDS];
   logic [31:0] shadow [MWORDS];
   logic [AW-1:0] q_addr [256];
   logic [31:0]   q_data [256];
   int q_wr = 0, q_rd = 0;

   dcache_wt #(.ADDR_W(AW), .IDX_W(IW), .WSEL_W(3), .DATA_W(32), .WB_DEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
      .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // memory write port: R5 order and alignment checked per handshake
   always @(posedge clk) begin
      if (rst_n && mem_wr_valid && mem_wr_ready) begin
         mem[mem_wr_addr[AW-1:2]] <= mem_wr_data;
         chk(q_rd < q_wr, "R5", "unexpected write", {16'd0, mem_wr_addr}, 32'd0);
         chk(mem_wr_addr == q_addr[q_rd[7:0]], "R5", "write address", {16'd0, mem_wr_addr},
             {16'd0, q_addr[q_rd[7:0]]});
         chk(mem_wr_data == q_data[q_rd[7:0]], "R5", "write data", mem_wr_data, q_data[q_rd[7:0]]);
         q_rd++;
      end
   end

   // refill responder: eight beats on consecutive falling edges
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_rd_req) begin
            logic [AW-1:0] base;
            base = mem_rd_addr;
            rd_cnt++;
            chk(base[4:0] == 5'd0, "R4", "refill address alignment", {16'd0, base}, 32'd0);
            chk(!mem_wr_valid, "R9", "refill while writes pending", {31'd0, mem_wr_valid}, 32'd0);
            for (int b = 0; b < 8; b++) begin
               @(negedge clk);
               mem_rd_valid = 1'b1;
               mem_rd_data  = mem[int'(base[AW-1:2]) + b];
            end
            @(negedge clk);
            mem_rd_valid = 1'b0;
            chk(!mem_rd_req, "R4", "refill request pulse", {31'd0, mem_rd_req}, 32'd0);
         end
      end
   end

   task automatic cpu_read(input logic [AW-1:0] a, input bit exp_hit,
                           input string rq, input int exp_lat);
      int lat, rc0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; rc0 = rd_cnt;
      #(CLK_P/4);
      chk(cpu_stall == !exp_hit, rq, "stall in first cycle", {31'd0, cpu_stall}, {31'd0, !exp_hit});
      lat = 0;
      while (cpu_stall && lat < 500) begin
         @(negedge clk); #(CLK_P/4); lat++;
      end
      if (exp_lat >= 0) chk(lat == exp_lat, rq, "stall cycles", lat, exp_lat);
      chk(cpu_rdata == shadow[a[AW-1:2]], rq, "read data", cpu_rdata, shadow[a[AW-1:2]]);
      chk((rd_cnt - rc0) == (exp_hit ? 0 : 1), rq, "refill count", rd_cnt - rc0, exp_hit ? 0 : 1);
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic cpu_write(input logic [AW-1:0] a, input logic [31:0] d, output int lat);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      #(CLK_P/4);
      lat = 0;
      while (cpu_stall && lat < 500) begin
         @(negedge clk); #(CLK_P/4); lat++;
      end
      @(posedge clk);
      shadow[a[AW-1:2]] = d;
      q_addr[q_wr[7:0]] = {a[AW-1:2], 2'b00};
      q_data[q_wr[7:0]] = d;
      q_wr++;
      #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int wl, bad;
      for (int i = 0; i < MWORDS; i++) begin
         mem[i]    = 32'(i) * 32'h9E37_79B1 + 32'h0123_4567;
         shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: sweep clear of NLINES cycles, then a 10-cycle refill
      cpu_read(16'h0000, 1'b0, "R2", NLINES + 9);

      // R4: fill every remaining line (tag 0)
      for (int l = 1; l < NLINES; l++) cpu_read(AW'(l * 32), 1'b0, "R4", 10);
      // R3 / R1: every word hits, byte select varied
      for (int l = 0; l < NLINES; l++)
         for (int w = 0; w < 8; w++) begin
            cpu_read(AW'(l * 32 + w * 4 + (w % 4)), 1'b1, "R1", 0);
         end
      cpu_read(16'h0044, 1'b1, "R3", 0);

      // R10: alias step is 2^(3+3+2) = 256 bytes in this configuration
      cpu_read(16'h0160, 1'b0, "R10", 10);
      cpu_read(16'h0068, 1'b0, "R10", 10);
      cpu_read(16'h0160, 1'b0, "R10", 10);

      // R6: write hit on line 5 word 3, neighbour unchanged
      cpu_write(16'h00AC, 32'hCAFE_0001, wl);
      cpu_read(16'h00AC, 1'b1, "R6", 0);
      cpu_read(16'h00B0, 1'b1, "R6", 0);
      // R5: byte bits set on a write; posted address must be word aligned
      cpu_write(16'h00B7, 32'h5EED_0005, wl);
      cpu_read(16'h00B4, 1'b1, "R5", 0);

      // R7: write miss to line 6 with tag 2; tag-0 line stays intact
      cpu_write(16'h02C4, 32'hB0B0_0007, wl);
      cpu_read(16'h00C4, 1'b1, "R7", 0);
      cpu_read(16'h02C4, 1'b0, "R7", -1);

      // R8: four writes fill the buffer, the fifth stalls
      repeat (4) @(negedge clk);
      mem_wr_ready = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cpu_write(AW'(16'h00E0 + k * 4), 32'hA000_0000 + 32'(k), wl);
         chk(wl == 0, "R8", "write into non-full buffer stalled", wl, 0);
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h00F0; cpu_wdata = 32'hA000_0004;
      #(CLK_P/4);
      chk(cpu_stall == 1'b1, "R8", "stall with full buffer", {31'd0, cpu_stall}, 32'd1);
      repeat (4) @(negedge clk);
      #(CLK_P/4);
      chk(cpu_stall == 1'b1, "R8", "stall held while blocked", {31'd0, cpu_stall}, 32'd1);
      @(negedge clk);
      mem_wr_ready = 1'b1;
      #(CLK_P/4);
      chk(cpu_stall == 1'b1, "R8", "stall before drain edge", {31'd0, cpu_stall}, 32'd1);
      @(negedge clk); #(CLK_P/4);
      chk(cpu_stall == 1'b0, "R8", "write taken after drain", {31'd0, cpu_stall}, 32'd0);
      @(posedge clk);
      shadow[16'h00F0 >> 2] = 32'hA000_0004;
      q_addr[q_wr[7:0]] = 16'h00F0; q_data[q_wr[7:0]] = 32'hA000_0004; q_wr++;
      #1; cpu_req = 1'b0; cpu_we = 1'b0;
      cpu_read(16'h00E8, 1'b1, "R6", 0);

      // R9: posted writes to the very words a miss will refill
      repeat (8) @(negedge clk);
      mem_wr_ready = 1'b0;
      cpu_write(16'h0340, 32'hD00D_0001, wl);
      cpu_write(16'h0344, 32'hD00D_0002, wl);
      fork
         begin
            repeat (6) @(negedge clk);
            mem_wr_ready = 1'b1;
         end
      join_none
      begin
         int rc0, lat;
         @(negedge clk);
         cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0344; rc0 = rd_cnt;
         #(CLK_P/4);
         lat = 0;
         while (cpu_stall && lat < 500) begin
            @(negedge clk); #(CLK_P/4); lat++;
         end
         chk(lat > 10, "R9", "miss waited for drain", lat, 11);
         chk(cpu_rdata == 32'hD00D_0002, "R9", "refill returns posted data", cpu_rdata, 32'hD00D_0002);
         chk(rd_cnt - rc0 == 1, "R9", "one refill", rd_cnt - rc0, 1);
         @(posedge clk); #1; cpu_req = 1'b0;
      end
      cpu_read(16'h0340, 1'b1, "R9", 0);

      repeat (10) @(negedge clk);
      chk(q_rd == q_wr, "R5", "all posted writes reached memory", q_rd, q_wr);
      bad = 0;
      for (int i = 0; i < MWORDS; i++) if (mem[i] !== shadow[i]) bad++;
      chk(bad == 0, "R5", "memory image mismatches", bad, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule